// File: doc/BRIEF.md
# Processor Subsystem Power-Up Sequencer

This block brings a processor subsystem from a held, powered-down condition to executing code after a single start pulse. It walks a fixed list of steps, one per clock edge except for a programmable settle interval: it puts the core and its bus port into reset, turns on the power head switch, waits for the rail to settle, wakes the memories (the three cache data banks one at a time to limit inrush current), removes the IO clamp, releases the core reset, enables the core clock and finally lets the core run. The reset, power and clock-gate controls are plain registered outputs that drive the subsystem's control bits directly.

Once the core runs, the sequencer watches a boot-status word supplied by the core's boot ROM. Any nonzero value ends the wait; the value 1 means success and any other nonzero value is an unexpected status. If the status stays zero for `TIMEOUT_MS` millisecond ticks the wait ends with a timeout. Either way a one-cycle `done` pulse is raised together with a held error code. A millisecond tick input paces the timeout, and the settle interval is `SETTLE_CYCLES` clock cycles (one microsecond at the intended clock).

States: `S_IDLE`, `S_RST` (assert reset group), `S_HEAD` (head switch and LDO bypass), `S_SETTLE` (settle wait), `S_MEM` (memory group), `S_BANK` (one data bank per visit, highest index first), `S_UNCLAMP`, `S_ARES_OFF` (release core reset), `S_CLK_ON`, `S_RUN` (clear core stop) and `S_POLL` (wait for boot status). Transitions: `S_IDLE` to `S_RST` on `start`; each step to the next unconditionally, except `S_SETTLE` to `S_MEM` when the settle count expires, `S_BANK` to `S_UNCLAMP` after bank 0, and `S_POLL` to `S_IDLE` on a nonzero status or timeout.

Top module: `pss_powerup_seq`

## Requirements
- R1: After reset `rst_ctl` is 0, `pwr_ctl` has only bit 20 (IO clamp) set, `clk_en` is 0, `done` is 0 and `err_code` is 0.
- R2: On the clock edge after the one that samples `start` in idle, `rst_ctl` bits 0 (core stop), 1 (core async reset) and 2 (bus async-reset enable) all become 1 in the same edge.
- R3: On the next edge `pwr_ctl` bits 21 (head switch) and 22 (LDO bypass) are set; then for `SETTLE_CYCLES` cycles no output changes.
- R4: On the edge after the settle interval, `pwr_ctl` bits 16 (tag memory), 17 (trace buffer), 18 (data standby) and 19 (retention sleep) are set together.
- R5: On the three following edges the data-bank enables are set one per edge in the order bit 2, bit 1, bit 0.
- R6: On the four following edges, one per edge and in this order: `pwr_ctl` bit 20 clears, `rst_ctl` bit 1 clears, `clk_en` sets, `rst_ctl` bit 0 clears.
- R7: While polling, a `boot_status` of 1 ends the wait: `done` pulses on the edge that samples it with `err_code` 0 (ok).
- R8: While polling, any other nonzero `boot_status` ends the wait with `err_code` 2 (unexpected status).
- R9: If `boot_status` stays zero, the edge that samples the `TIMEOUT_MS`-th `ms_tick` of the polling phase ends the wait with `err_code` 1 (timeout); ticks before polling are not counted, and a nonzero status in the same cycle as that tick takes priority.
- R10: `done` lasts exactly one cycle; `err_code` holds until the next accepted start, which clears it to 0.
- R11: A `start` pulse while a sequence is in progress is ignored: output timing is unchanged and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the power-up sequence (sampled in idle only) |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| boot_status | input | STATUS_W | Status word from the core boot ROM |
| rst_ctl | output | 3 | Reset controls: bit 0 core stop, bit 1 core async reset, bit 2 bus async-reset enable |
| pwr_ctl | output | 23 | Power controls at fixed bit positions (banks 0-2, tag 16, trace 17, standby 18, retention 19, clamp 20, head 21, LDO bypass 22) |
| clk_en | output | 1 | Core clock-gate enable |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 timeout, 2 unexpected status |

## Verification
Counting the edge that samples `start` as edge 1, the reset group appears after edge 2, the head switch after edge 3, the memory group after edge 4+S (S being `SETTLE_CYCLES`), the banks after edges 5+S to 7+S, the four release steps after edges 8+S to 11+S, and a status already present yields `done` after edge 12+S; a final timeout tick or status change shows up after the very edge that samples it. The bench drives on falling edges and compares every output at each falling edge against a step-indexed model of this schedule, so a step that is early, late, merged with a neighbour or repeated is caught in the cycle it happens.

// File: rtl/pss_seq_pkg.sv
package pss_seq_pkg;

    // Reset-control bit positions
    localparam int RC_STOP     = 0;
    localparam int RC_CORE_RST = 1;
    localparam int RC_BUS_RST  = 2;
    localparam int RC_W        = 3;

    // Power-control bit positions (decoded by the subsystem)
    localparam int PC_BANK0    = 0;
    localparam int PC_TAG      = 16;
    localparam int PC_TRACE    = 17;
    localparam int PC_STBY     = 18;
    localparam int PC_RET      = 19;
    localparam int PC_CLAMP    = 20;
    localparam int PC_HEAD     = 21;
    localparam int PC_LDO_BYP  = 22;
    localparam int PC_W        = 23;

    localparam int NUM_BANKS   = 3;
    localparam int BANK_IDX_W  = $clog2(NUM_BANKS);

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST,
        S_HEAD,
        S_SETTLE,
        S_MEM,
        S_BANK,
        S_UNCLAMP,
        S_ARES_OFF,
        S_CLK_ON,
        S_RUN,
        S_POLL
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_STATUS  = 2'd2
    } seq_err_t;

endpackage

// File: rtl/pss_tick_counter.sv
module pss_tick_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = inc && !clear && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/pss_status_eval.sv
module pss_status_eval #(
    parameter int STATUS_W = 32
) (
    input  logic [STATUS_W-1:0] status,
    output logic                seen,
    output logic                good
);
    assign seen = |status;
    assign good = (status == STATUS_W'(1));
endmodule

// File: rtl/pss_powerup_seq.sv
module pss_powerup_seq
    import pss_seq_pkg::*;
#(
    parameter int SETTLE_CYCLES = 200,
    parameter int TIMEOUT_MS    = 1000,
    parameter int STATUS_W      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                ms_tick,
    input  logic [STATUS_W-1:0] boot_status,
    output logic [RC_W-1:0]     rst_ctl,
    output logic [PC_W-1:0]     pwr_ctl,
    output logic                clk_en,
    output logic                done,
    output logic [1:0]          err_code
);
    localparam logic [BANK_IDX_W-1:0] TOP_BANK = BANK_IDX_W'(NUM_BANKS - 1);

    seq_state_t            state, state_nx;
    logic [BANK_IDX_W-1:0] bank_idx;
    logic                  settle_exp, tmo_exp;
    logic                  st_seen, st_good;

    pss_tick_counter #(.LIMIT(SETTLE_CYCLES)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state != S_SETTLE),
        .inc    (1'b1),
        .expire (settle_exp)
    );

    pss_tick_counter #(.LIMIT(TIMEOUT_MS)) u_timeout (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state != S_POLL),
        .inc    (ms_tick),
        .expire (tmo_exp)
    );

    pss_status_eval #(.STATUS_W(STATUS_W)) u_eval (
        .status (boot_status),
        .seen   (st_seen),
        .good   (st_good)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start) state_nx = S_RST;
            S_RST:      state_nx = S_HEAD;
            S_HEAD:     state_nx = S_SETTLE;
            S_SETTLE:   if (settle_exp) state_nx = S_MEM;
            S_MEM:      state_nx = S_BANK;
            S_BANK:     if (bank_idx == '0) state_nx = S_UNCLAMP;
            S_UNCLAMP:  state_nx = S_ARES_OFF;
            S_ARES_OFF: state_nx = S_CLK_ON;
            S_CLK_ON:   state_nx = S_RUN;
            S_RUN:      state_nx = S_POLL;
            S_POLL:     if (st_seen || tmo_exp) state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_ctl  <= '0;
            pwr_ctl  <= PC_W'(1) << PC_CLAMP;
            clk_en   <= 1'b0;
            done     <= 1'b0;
            err_code <= ERR_NONE;
            bank_idx <= TOP_BANK;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) err_code <= ERR_NONE;
                end
                S_RST: begin
                    rst_ctl[RC_STOP]     <= 1'b1;
                    rst_ctl[RC_CORE_RST] <= 1'b1;
                    rst_ctl[RC_BUS_RST]  <= 1'b1;
                end
                S_HEAD: begin
                    pwr_ctl[PC_HEAD]    <= 1'b1;
                    pwr_ctl[PC_LDO_BYP] <= 1'b1;
                end
                S_SETTLE: begin
                end
                S_MEM: begin
                    pwr_ctl[PC_RET]   <= 1'b1;
                    pwr_ctl[PC_TAG]   <= 1'b1;
                    pwr_ctl[PC_TRACE] <= 1'b1;
                    pwr_ctl[PC_STBY]  <= 1'b1;
                    bank_idx          <= TOP_BANK;
                end
                S_BANK: begin
                    pwr_ctl[PC_BANK0 + int'(bank_idx)] <= 1'b1;
                    if (bank_idx != '0) bank_idx <= bank_idx - 1'b1;
                end
                S_UNCLAMP:  pwr_ctl[PC_CLAMP]    <= 1'b0;
                S_ARES_OFF: rst_ctl[RC_CORE_RST] <= 1'b0;
                S_CLK_ON:   clk_en               <= 1'b1;
                S_RUN:      rst_ctl[RC_STOP]     <= 1'b0;
                S_POLL: begin
                    if (st_seen) begin
                        done     <= 1'b1;
                        err_code <= st_good ? ERR_NONE : ERR_STATUS;
                    end else if (tmo_exp) begin
                        done     <= 1'b1;
                        err_code <= ERR_TIMEOUT;
                    end
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/pss_powerup_seq_chk.sv
module pss_powerup_seq_chk
    import pss_seq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [RC_W-1:0] rst_ctl,
    input logic [PC_W-1:0] pwr_ctl,
    input logic            clk_en,
    input logic            done,
    input logic [1:0]      err_code
);
    assert_reset_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_ctl[RC_CORE_RST]) |-> rst_ctl[RC_STOP] && rst_ctl[RC_BUS_RST]);

    assert_mem_after_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_ctl[PC_RET] |-> pwr_ctl[PC_HEAD] && pwr_ctl[PC_LDO_BYP]);

    assert_bank1_after_bank2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ctl[PC_BANK0 + 1]) |-> $past(pwr_ctl[PC_BANK0 + 2]));

    assert_bank0_after_bank1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ctl[PC_BANK0]) |-> $past(pwr_ctl[PC_BANK0 + 1]));

    assert_unclamp_after_banks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_ctl[PC_CLAMP]) |-> (pwr_ctl[PC_BANK0 +: NUM_BANKS] == '1));

    assert_clk_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> !rst_ctl[RC_CORE_RST] && rst_ctl[RC_STOP]);

    assert_stop_clear_after_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_ctl[RC_STOP]) |-> clk_en);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_code != 2'd3);
endmodule

bind pss_powerup_seq pss_powerup_seq_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ctl  (rst_ctl),
    .pwr_ctl  (pwr_ctl),
    .clk_en   (clk_en),
    .done     (done),
    .err_code (err_code)
);

// File: tb/test_pss_powerup_seq.sv
`timescale 1ns/1ps
module test_pss_powerup_seq;
    localparam int S  = 6;
    localparam int T  = 4;
    localparam int SW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          ms_tick = 1'b0;
    logic [SW-1:0] boot_status = '0;
    logic [2:0]    rst_ctl;
    logic [22:0]   pwr_ctl;
    logic          clk_en;
    logic          done;
    logic [1:0]    err_code;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pss_powerup_seq #(.SETTLE_CYCLES(S), .TIMEOUT_MS(T), .STATUS_W(SW)) i_pss_powerup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
        .boot_status(boot_status), .rst_ctl(rst_ctl), .pwr_ctl(pwr_ctl),
        .clk_en(clk_en), .done(done), .err_code(err_code)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; ms_tick = 1'b0; boot_status = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Pulse start; returns at the falling edge after the sampling edge (edge 1)
    task automatic kick();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic test_reset_R1();
        do_reset();
        check("R1", "rst_ctl", 32'(rst_ctl), 32'h0);
        check("R1", "pwr_ctl", 32'(pwr_ctl), 32'h0010_0000);
        check("R1", "clk_en", 32'(clk_en), 32'h0);
        check("R1", "done", 32'(done), 32'h0);
        check("R1", "err_code", 32'(err_code), 32'h0);
    endtask

    // Full step-by-step trace from a fresh reset; status already present
    task automatic trace_run(input logic [SW-1:0] st, input bit spam);
        logic [2:0]  e_rst;
        logic [22:0] e_pwr;
        string tag;
        boot_status = st;
        kick();
        for (int j = 1; j <= 14 + S; j++) begin
            if (j > 1) begin
                if (spam && (j == 3 || j == 5 + S || j == 12 + S)) start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            e_rst = (j >= 2) ? 3'b111 : 3'b000;
            if (j >= 9 + S)  e_rst[1] = 1'b0;
            if (j >= 11 + S) e_rst[0] = 1'b0;
            e_pwr = 23'h10_0000;
            if (j >= 3)     e_pwr = e_pwr | 23'h60_0000;
            if (j >= 4 + S) e_pwr = e_pwr | 23'h0F_0000;
            if (j >= 5 + S) e_pwr[2] = 1'b1;
            if (j >= 6 + S) e_pwr[1] = 1'b1;
            if (j >= 7 + S) e_pwr[0] = 1'b1;
            if (j >= 8 + S) e_pwr[20] = 1'b0;
            if (spam)            tag = "R11";
            else if (j == 1)     tag = "R1";
            else if (j == 2)     tag = "R2";
            else if (j <= 3 + S) tag = "R3";
            else if (j == 4 + S) tag = "R4";
            else if (j <= 7 + S) tag = "R5";
            else if (j <= 11 + S) tag = "R6";
            else if (st == 1)    tag = "R7";
            else                 tag = "R8";
            check(tag, "rst_ctl", 32'(rst_ctl), 32'(e_rst));
            check(tag, "pwr_ctl", 32'(pwr_ctl), 32'(e_pwr));
            check(tag, "clk_en", 32'(clk_en), 32'(j >= 10 + S));
            check(tag, "done", 32'(done), 32'(j == 12 + S));
            if (j >= 12 + S)
                check(tag, "err_code", 32'(err_code), (st == 1) ? 32'd0 : 32'd2);
        end
    endtask

    // Run to the polling phase with zero status; ticks held high meanwhile
    task automatic to_poll_with_ticks();
        boot_status = '0;
        ms_tick = 1'b1;
        kick();
        repeat (10 + S) @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic test_timeout_R9();
        do_reset();
        to_poll_with_ticks();
        for (int i = 1; i <= T; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            check("R9", "done on tick", 32'(done), 32'(i == T));
            if (i == T) check("R9", "err timeout", 32'(err_code), 32'd1);
            else begin
                @(negedge clk);
                check("R9", "done between ticks", 32'(done), 32'd0);
            end
        end
        @(negedge clk);
        check("R10", "done one cycle", 32'(done), 32'd0);
        check("R10", "err held", 32'(err_code), 32'd1);
    endtask

    task automatic test_status_priority_R9();
        do_reset();
        to_poll_with_ticks();
        for (int i = 1; i <= T; i++) begin
            ms_tick = 1'b1;
            if (i == T) boot_status = 32'd1;
            @(negedge clk);
            ms_tick = 1'b0;
            check("R9", "done", 32'(done), 32'(i == T));
        end
        check("R9", "status wins over final tick", 32'(err_code), 32'd0);
    endtask

    task automatic test_err_hold_R10();
        do_reset();
        trace_run(32'h5, 1'b0);
        repeat (3) @(negedge clk);
        check("R10", "done low", 32'(done), 32'd0);
        check("R10", "err held", 32'(err_code), 32'd2);
        boot_status = 32'd1;
        kick();
        check("R10", "err cleared by start", 32'(err_code), 32'd0);
        repeat (10 + S) @(negedge clk);
        check("R10", "done not early", 32'(done), 32'd0);
        @(negedge clk);
        check("R7", "done on rerun", 32'(done), 32'd1);
        check("R7", "err ok on rerun", 32'(err_code), 32'd0);
    endtask

    initial begin
        test_reset_R1();
        do_reset();
        trace_run(32'h1, 1'b0);
        do_reset();
        trace_run(32'h8000_0000, 1'b0);
        do_reset();
        trace_run(32'h1, 1'b1);
        test_timeout_R9();
        test_status_priority_R9();
        test_err_hold_R10();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule